// File: doc/BRIEF.md
# Rank Bank Row Column Address Walker

This block produces the address sequence for a memory test engine that drives one channel. It holds four address fields (column, row, bank and rank). Each field has its own start value, wrap limit, step size and update rate. Every cacheline command issued by the engine pulses `advance`. A field steps when its own rate counter reaches the programmed rate, or when the field one place below it in the carry chain wraps with its carry enabled. The carry chain order is programmable. A pulse on `restart` puts every field back at its start value.

A field that would pass its wrap limit on a step reloads its start value instead, and that counts as a wrap. A wrap in a field whose trigger enable is set raises `wrapTrig` for one cycle. The test engine uses that pulse to end the test. The column field counts in units of eight, so the column output always has its three low bits at zero. The rank output is the logical rank index. Mapping it to a physical rank, and issuing the commands, belong to other blocks.

Top module: `addrWalker`

## Requirements
- R1: While reset is held, and right after it, all four address outputs and `wrapTrig` are 0.
- R2: A `restart` pulse loads every field with its start value at the next clock edge and clears every rate counter. It takes priority over an `advance` in the same cycle, and that cycle causes no step and no trigger.
- R3: `colAddr` is the column field multiplied by 8, so `colAddr[2:0]` is always 0.
- R4: When a field steps and field+increment is no greater than its wrap value, the field becomes field+increment. Otherwise it reloads its start value, and that counts as a wrap.
- R5: For the column, bank and rank rates (8 bits) with bit 7 set, and for the row rate (6 bits) with bit 5 set, the low bits N give a linear rate. The field steps on every Nth `advance`, and N=0 means the field never steps from its own rate.
- R6: When that top bit is clear, the low bits E are an exponent. The field steps on every 2^E-th `advance`.
- R7: `fieldOrder` holds 2 bits per field: column at [1:0], row at [3:2], bank at [5:4], rank at [7:6]. Chain position 0 comes first. A wrap in a field with its `carryEn` bit set steps the field at the next position in the same `advance`. With the carry bit clear, no carry is passed. `carryEn` and `trigEn` bits are indexed column 0, row 1, bank 2, rank 3.
- R8: If a field's own rate is reached and a carry arrives in the same `advance`, the field steps once. Its rate counter returns to 0 on every step, whether rate-driven or carry-driven.
- R9: `wrapTrig` is high for exactly the one cycle after an `advance` edge in which a field with its `trigEn` bit set wrapped. Carry does not need to be enabled for this. At all other times `wrapTrig` is low.
- R10: With `advance` and `restart` both low, every address output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| advance | input | 1 | One pulse per cacheline command |
| restart | input | 1 | Reload all fields with their start values |
| colStart | input | 8 | Column start, in units of 8 |
| colWrap | input | 8 | Column wrap limit, in units of 8 |
| colInc | input | 8 | Column step, in units of 8 |
| colRate | input | 8 | Column update-rate code |
| rowStart | input | 16 | Row start |
| rowWrap | input | 16 | Row wrap limit |
| rowInc | input | 12 | Row step |
| rowRate | input | 6 | Row update-rate code |
| bankStart | input | 3 | Bank start |
| bankWrap | input | 3 | Bank wrap limit |
| bankInc | input | 3 | Bank step |
| bankRate | input | 8 | Bank update-rate code |
| rankStart | input | 3 | Rank start |
| rankWrap | input | 3 | Rank wrap limit |
| rankInc | input | 3 | Rank step |
| rankRate | input | 8 | Rank update-rate code |
| fieldOrder | input | 8 | Carry-chain position of each field, 2 bits each |
| carryEn | input | 4 | Per-field wrap-carry enable |
| trigEn | input | 4 | Per-field wrap-trigger enable |
| colAddr | output | 11 | Current column address |
| rowAddr | output | 16 | Current row address |
| bankAddr | output | 3 | Current bank |
| rankAddr | output | 3 | Current logical rank |
| wrapTrig | output | 1 | One-cycle wrap-trigger event |

## Verification
Two events can fall on the same `advance`: a field reaching its own update rate, and a carry arriving from the field below it in the chain. The bench sets up both in one cycle. It programs a row rate of 2 while the column, with carry enabled, wraps every second strobe. It then checks that the row moved by one increment and not two. A second setup uses a row rate of 3, where a carry alone must clear the row's rate counter. If that counter were not cleared, the row would step one strobe early, and the bench checks the row at that strobe. `restart` together with `advance` is also exercised, and the start values must win.

// File: rtl/addr_walk_pkg.sv
package addr_walk_pkg;
  localparam int NF = 4;
  localparam int OW = $clog2(NF);
  localparam int F_COL = 0;
  localparam int F_ROW = 1;
  localparam int F_BANK = 2;
  localparam int F_RANK = 3;

  typedef struct packed {
    logic [NF-1:0] step;
    logic          restart;
  } walkStrobe_t;
endpackage

// File: rtl/walkField.sv
module walkField #(
  parameter int AW = 8,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          restart,
  input  logic          step,
  input  logic [AW-1:0] start,
  input  logic [AW-1:0] wrapVal,
  input  logic [IW-1:0] inc,
  output logic [AW-1:0] cur,
  output logic          wouldWrap
);
  localparam int SW = ((AW > IW) ? AW : IW) + 1;

  logic [SW-1:0] sum;

  assign sum       = SW'(cur) + SW'(inc);
  assign wouldWrap = sum > SW'(wrapVal);

  always_ff @(posedge clk) begin
    if (!rstN)          cur <= '0;
    else if (restart)   cur <= start;
    else if (step)      cur <= wouldWrap ? start : sum[AW-1:0];
  end

  p_restart_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> cur == $past(start));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!restart && !step) |=> $stable(cur));

  p_wrap_reload_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!restart && step && wouldWrap) |=> cur == $past(start));
endmodule

// File: rtl/walkCtrl.sv
module walkCtrl
  import addr_walk_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int RV_W  = 7
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     advance,
  input  logic                     restart,
  input  logic [NF-1:0]            rateLin,
  input  logic [NF-1:0][RV_W-1:0]  rateVal,
  input  logic [NF-1:0][OW-1:0]    fieldOrder,
  input  logic [NF-1:0]            carryEn,
  input  logic [NF-1:0]            trigEn,
  input  logic [NF-1:0]            wouldWrap,
  output walkStrobe_t              strobe,
  output logic                     wrapTrig
);
  logic [NF-1:0][CNT_W:0]   target;
  logic [NF-1:0][CNT_W-1:0] rateCnt;
  logic [NF-1:0]            rateOn;
  logic [NF-1:0]            rateHit;
  logic [NF-1:0]            stepV;
  logic [NF-1:0]            wrapped;
  logic [NF:0]              carryPos;

  for (genvar g = 0; g < NF; g++) begin : gRate
    always_comb begin
      if (rateLin[g]) begin
        target[g] = (CNT_W+1)'(rateVal[g]);
        rateOn[g] = rateVal[g] != '0;
      end else begin
        target[g] = (CNT_W+1)'(1) << rateVal[g];
        rateOn[g] = int'(rateVal[g]) < CNT_W;
      end
      rateHit[g] = rateOn[g] && ({1'b0, rateCnt[g]} == target[g] - (CNT_W+1)'(1));
    end

    always_ff @(posedge clk) begin
      if (!rstN)                      rateCnt[g] <= '0;
      else if (restart || stepV[g])   rateCnt[g] <= '0;
      else if (advance)               rateCnt[g] <= rateCnt[g] + CNT_W'(1);
    end
  end

  always_comb begin
    carryPos = '0;
    stepV    = '0;
    wrapped  = '0;
    for (int p = 0; p < NF; p++) begin
      for (int f = 0; f < NF; f++) begin
        if (int'(fieldOrder[f]) == p) begin
          stepV[f]   = advance && !restart && (rateHit[f] || carryPos[p]);
          wrapped[f] = stepV[f] && wouldWrap[f];
          if (wrapped[f] && carryEn[f]) carryPos[p+1] = 1'b1;
        end
      end
    end
  end

  assign strobe.step    = stepV;
  assign strobe.restart = restart;

  always_ff @(posedge clk) begin
    if (!rstN) wrapTrig <= 1'b0;
    else       wrapTrig <= |(wrapped & trigEn);
  end

  p_trig_after_adv_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrapTrig |-> $past(advance && !restart));
endmodule

// File: rtl/walkPath.sv
module walkPath
  import addr_walk_pkg::*;
#(
  parameter int COL_W   = 8,
  parameter int ROW_W   = 16,
  parameter int BANK_W  = 3,
  parameter int RANK_W  = 3,
  parameter int COLI_W  = 8,
  parameter int ROWI_W  = 12,
  parameter int BANKI_W = 3,
  parameter int RANKI_W = 3,
  parameter int COL_LSB = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  walkStrobe_t              strobe,
  input  logic [COL_W-1:0]         colStart,
  input  logic [COL_W-1:0]         colWrap,
  input  logic [COLI_W-1:0]        colInc,
  input  logic [ROW_W-1:0]         rowStart,
  input  logic [ROW_W-1:0]         rowWrap,
  input  logic [ROWI_W-1:0]        rowInc,
  input  logic [BANK_W-1:0]        bankStart,
  input  logic [BANK_W-1:0]        bankWrap,
  input  logic [BANKI_W-1:0]       bankInc,
  input  logic [RANK_W-1:0]        rankStart,
  input  logic [RANK_W-1:0]        rankWrap,
  input  logic [RANKI_W-1:0]       rankInc,
  output logic [COL_W+COL_LSB-1:0] colAddr,
  output logic [ROW_W-1:0]         rowAddr,
  output logic [BANK_W-1:0]        bankAddr,
  output logic [RANK_W-1:0]        rankAddr,
  output logic [NF-1:0]            wouldWrap
);
  logic [COL_W-1:0] colCur;

  walkField #(.AW(COL_W), .IW(COLI_W)) uCol (
    .clk(clk), .rstN(rstN), .restart(strobe.restart), .step(strobe.step[F_COL]),
    .start(colStart), .wrapVal(colWrap), .inc(colInc),
    .cur(colCur), .wouldWrap(wouldWrap[F_COL]));

  walkField #(.AW(ROW_W), .IW(ROWI_W)) uRow (
    .clk(clk), .rstN(rstN), .restart(strobe.restart), .step(strobe.step[F_ROW]),
    .start(rowStart), .wrapVal(rowWrap), .inc(rowInc),
    .cur(rowAddr), .wouldWrap(wouldWrap[F_ROW]));

  walkField #(.AW(BANK_W), .IW(BANKI_W)) uBank (
    .clk(clk), .rstN(rstN), .restart(strobe.restart), .step(strobe.step[F_BANK]),
    .start(bankStart), .wrapVal(bankWrap), .inc(bankInc),
    .cur(bankAddr), .wouldWrap(wouldWrap[F_BANK]));

  walkField #(.AW(RANK_W), .IW(RANKI_W)) uRank (
    .clk(clk), .rstN(rstN), .restart(strobe.restart), .step(strobe.step[F_RANK]),
    .start(rankStart), .wrapVal(rankWrap), .inc(rankInc),
    .cur(rankAddr), .wouldWrap(wouldWrap[F_RANK]));

  assign colAddr = {colCur, {COL_LSB{1'b0}}};
endmodule

// File: rtl/addrWalker.sv
module addrWalker
  import addr_walk_pkg::*;
#(
  parameter int COL_W   = 8,
  parameter int ROW_W   = 16,
  parameter int BANK_W  = 3,
  parameter int RANK_W  = 3,
  parameter int COLI_W  = 8,
  parameter int ROWI_W  = 12,
  parameter int BANKI_W = 3,
  parameter int RANKI_W = 3,
  parameter int RATE_W  = 8,
  parameter int RRATE_W = 6,
  parameter int CNT_W   = 16,
  parameter int COL_LSB = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     advance,
  input  logic                     restart,
  input  logic [COL_W-1:0]         colStart,
  input  logic [COL_W-1:0]         colWrap,
  input  logic [COLI_W-1:0]        colInc,
  input  logic [RATE_W-1:0]        colRate,
  input  logic [ROW_W-1:0]         rowStart,
  input  logic [ROW_W-1:0]         rowWrap,
  input  logic [ROWI_W-1:0]        rowInc,
  input  logic [RRATE_W-1:0]       rowRate,
  input  logic [BANK_W-1:0]        bankStart,
  input  logic [BANK_W-1:0]        bankWrap,
  input  logic [BANKI_W-1:0]       bankInc,
  input  logic [RATE_W-1:0]        bankRate,
  input  logic [RANK_W-1:0]        rankStart,
  input  logic [RANK_W-1:0]        rankWrap,
  input  logic [RANKI_W-1:0]       rankInc,
  input  logic [RATE_W-1:0]        rankRate,
  input  logic [NF*OW-1:0]         fieldOrder,
  input  logic [NF-1:0]            carryEn,
  input  logic [NF-1:0]            trigEn,
  output logic [COL_W+COL_LSB-1:0] colAddr,
  output logic [ROW_W-1:0]         rowAddr,
  output logic [BANK_W-1:0]        bankAddr,
  output logic [RANK_W-1:0]        rankAddr,
  output logic                     wrapTrig
);
  localparam int RV_W = RATE_W - 1;

  logic [NF-1:0]           rateLin;
  logic [NF-1:0][RV_W-1:0] rateVal;
  logic [NF-1:0]           wouldWrap;
  walkStrobe_t             strobe;

  assign rateLin[F_COL]  = colRate[RATE_W-1];
  assign rateLin[F_ROW]  = rowRate[RRATE_W-1];
  assign rateLin[F_BANK] = bankRate[RATE_W-1];
  assign rateLin[F_RANK] = rankRate[RATE_W-1];
  assign rateVal[F_COL]  = colRate[RV_W-1:0];
  assign rateVal[F_ROW]  = RV_W'(rowRate[RRATE_W-2:0]);
  assign rateVal[F_BANK] = bankRate[RV_W-1:0];
  assign rateVal[F_RANK] = rankRate[RV_W-1:0];

  walkCtrl #(.CNT_W(CNT_W), .RV_W(RV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .advance(advance), .restart(restart),
    .rateLin(rateLin), .rateVal(rateVal), .fieldOrder(fieldOrder),
    .carryEn(carryEn), .trigEn(trigEn), .wouldWrap(wouldWrap),
    .strobe(strobe), .wrapTrig(wrapTrig));

  walkPath #(
    .COL_W(COL_W), .ROW_W(ROW_W), .BANK_W(BANK_W), .RANK_W(RANK_W),
    .COLI_W(COLI_W), .ROWI_W(ROWI_W), .BANKI_W(BANKI_W), .RANKI_W(RANKI_W),
    .COL_LSB(COL_LSB)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .colStart(colStart), .colWrap(colWrap), .colInc(colInc),
    .rowStart(rowStart), .rowWrap(rowWrap), .rowInc(rowInc),
    .bankStart(bankStart), .bankWrap(bankWrap), .bankInc(bankInc),
    .rankStart(rankStart), .rankWrap(rankWrap), .rankInc(rankInc),
    .colAddr(colAddr), .rowAddr(rowAddr), .bankAddr(bankAddr), .rankAddr(rankAddr),
    .wouldWrap(wouldWrap));
endmodule

// File: tb/tb_addrWalker.sv
module tb_addrWalker;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic advance = 1'b0, restart = 1'b0;
  logic [7:0]  colStart, colWrap, colInc, colRate;
  logic [15:0] rowStart, rowWrap;
  logic [11:0] rowInc;
  logic [5:0]  rowRate;
  logic [2:0]  bankStart, bankWrap, bankInc, rankStart, rankWrap, rankInc;
  logic [7:0]  bankRate, rankRate, fieldOrder;
  logic [3:0]  carryEn, trigEn;
  logic [10:0] colAddr;
  logic [15:0] rowAddr;
  logic [2:0]  bankAddr, rankAddr;
  logic        wrapTrig;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  addrWalker dut (
    .clk(clk), .rstN(rstN), .advance(advance), .restart(restart),
    .colStart(colStart), .colWrap(colWrap), .colInc(colInc), .colRate(colRate),
    .rowStart(rowStart), .rowWrap(rowWrap), .rowInc(rowInc), .rowRate(rowRate),
    .bankStart(bankStart), .bankWrap(bankWrap), .bankInc(bankInc), .bankRate(bankRate),
    .rankStart(rankStart), .rankWrap(rankWrap), .rankInc(rankInc), .rankRate(rankRate),
    .fieldOrder(fieldOrder), .carryEn(carryEn), .trigEn(trigEn),
    .colAddr(colAddr), .rowAddr(rowAddr), .bankAddr(bankAddr), .rankAddr(rankAddr),
    .wrapTrig(wrapTrig));

  // {adv, rst, col[10:0], row[15:0], bank[2:0], rank[2:0], trig}
  localparam int NV = 16;
  localparam logic [35:0] VEC [NV] = '{
    {1'b0, 1'b1, 11'd8,  16'd10, 3'd2, 3'd0, 1'b0},
    {1'b1, 1'b0, 11'd16, 16'd10, 3'd2, 3'd0, 1'b0},
    {1'b1, 1'b0, 11'd24, 16'd10, 3'd2, 3'd0, 1'b0},
    {1'b1, 1'b0, 11'd32, 16'd10, 3'd2, 3'd0, 1'b0},
    {1'b1, 1'b0, 11'd8,  16'd20, 3'd2, 3'd0, 1'b0},
    {1'b1, 1'b0, 11'd16, 16'd20, 3'd2, 3'd0, 1'b0},
    {1'b1, 1'b0, 11'd24, 16'd20, 3'd2, 3'd0, 1'b0},
    {1'b1, 1'b0, 11'd32, 16'd20, 3'd2, 3'd0, 1'b0},
    {1'b1, 1'b0, 11'd8,  16'd30, 3'd2, 3'd0, 1'b0},
    {1'b1, 1'b0, 11'd16, 16'd30, 3'd2, 3'd0, 1'b0},
    {1'b1, 1'b0, 11'd24, 16'd30, 3'd2, 3'd0, 1'b0},
    {1'b1, 1'b0, 11'd32, 16'd30, 3'd2, 3'd0, 1'b0},
    {1'b1, 1'b0, 11'd8,  16'd10, 3'd3, 3'd0, 1'b1},
    {1'b0, 1'b0, 11'd8,  16'd10, 3'd3, 3'd0, 1'b0},
    {1'b1, 1'b1, 11'd8,  16'd10, 3'd2, 3'd0, 1'b0},
    {1'b1, 1'b0, 11'd16, 16'd10, 3'd2, 3'd0, 1'b0}
  };

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic stepOnce(input logic a, input logic r);
    advance = a;
    restart = r;
    @(posedge clk);
    #1;
    advance = 1'b0;
    restart = 1'b0;
    @(negedge clk);
  endtask

  task automatic advN(input int n);
    for (int i = 0; i < n; i++) stepOnce(1'b1, 1'b0);
  endtask

  task automatic setDefaults();
    colStart = '0; colWrap = '0; colInc = '0; colRate = 8'h80;
    rowStart = '0; rowWrap = '0; rowInc = '0; rowRate = 6'h20;
    bankStart = '0; bankWrap = '0; bankInc = '0; bankRate = 8'h80;
    rankStart = '0; rankWrap = '0; rankInc = '0; rankRate = 8'h80;
    fieldOrder = 8'hE4; carryEn = '0; trigEn = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    setDefaults();
    colStart = 8'd5; rowStart = 16'd7; bankStart = 3'd1; rankStart = 3'd2;
    repeat (3) @(negedge clk);
    // R1: outputs cleared under reset
    chk("R1 col", colAddr, 0);
    chk("R1 row", rowAddr, 0);
    chk("R1 bank", bankAddr, 0);
    chk("R1 rank", rankAddr, 0);
    chk("R1 trig", wrapTrig, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 col after release", colAddr, 0);

    // Table run: column every strobe, carries to row, row carries to bank
    colStart = 8'd1; colWrap = 8'd4; colInc = 8'd1; colRate = 8'h81;
    rowStart = 16'd10; rowWrap = 16'd30; rowInc = 12'd10;
    bankStart = 3'd2; bankWrap = 3'd3; bankInc = 3'd1;
    rankStart = 3'd0;
    carryEn = 4'b0011; trigEn = 4'b0010;
    for (int v = 0; v < NV; v++) begin
      stepOnce(VEC[v][35], VEC[v][34]);
      chk($sformatf("R2 R3 R4 R7 vec%0d col", v), colAddr, int'(VEC[v][33:23]));
      chk($sformatf("R4 R7 R10 vec%0d row", v), rowAddr, int'(VEC[v][22:7]));
      chk($sformatf("R7 vec%0d bank", v), bankAddr, int'(VEC[v][6:4]));
      chk($sformatf("R2 vec%0d rank", v), rankAddr, int'(VEC[v][3:1]));
      chk($sformatf("R9 vec%0d trig", v), wrapTrig, int'(VEC[v][0]));
    end

    // R6: exponent rates (column 2^2, row 2^1)
    setDefaults();
    colWrap = 8'd255; colInc = 8'd1; colRate = 8'h02;
    rowWrap = 16'd100; rowInc = 12'd5; rowRate = 6'h01;
    stepOnce(1'b0, 1'b1);
    advN(2);
    chk("R6 col after 2", colAddr, 0);
    chk("R6 row after 2", rowAddr, 5);
    advN(2);
    chk("R6 col after 4", colAddr, 8);
    chk("R6 row after 4", rowAddr, 10);

    // R5: linear rate 3, linear rate 0 never steps
    setDefaults();
    colWrap = 8'd255; colInc = 8'd1; colRate = 8'h83;
    bankWrap = 3'd7; bankInc = 3'd1; bankRate = 8'h80;
    stepOnce(1'b0, 1'b1);
    advN(2);
    chk("R5 col after 2", colAddr, 0);
    advN(1);
    chk("R5 col after 3", colAddr, 8);
    chk("R5 bank rate zero", bankAddr, 0);

    // R8: own rate hit and carry in the same strobe
    setDefaults();
    colWrap = 8'd1; colInc = 8'd1; colRate = 8'h81;
    rowWrap = 16'd100; rowInc = 12'd1; rowRate = 6'h22;
    carryEn = 4'b0001;
    stepOnce(1'b0, 1'b1);
    advN(1);
    chk("R8 col after 1", colAddr, 8);
    chk("R8 row after 1", rowAddr, 0);
    advN(1);
    chk("R8 col wrap", colAddr, 0);
    chk("R8 coincident single step", rowAddr, 1);

    // R8: carry-only step clears the row rate counter
    rowRate = 6'h23;
    stepOnce(1'b0, 1'b1);
    advN(2);
    chk("R8 carry step", rowAddr, 1);
    advN(1);
    chk("R8 counter cleared by carry", rowAddr, 1);
    advN(1);
    chk("R8 second carry", rowAddr, 2);

    // R7: rank first in chain, carries into column
    setDefaults();
    fieldOrder = 8'h39;
    rankWrap = 3'd1; rankInc = 3'd1; rankRate = 8'h81;
    colWrap = 8'd10; colInc = 8'd2;
    carryEn = 4'b1000;
    stepOnce(1'b0, 1'b1);
    advN(1);
    chk("R7 rank step", rankAddr, 1);
    chk("R7 col waits", colAddr, 0);
    advN(1);
    chk("R7 rank wrap", rankAddr, 0);
    chk("R7 carry to col", colAddr, 16);

    // R7 R9: carry disabled, trigger enabled on rank
    carryEn = 4'b0000; trigEn = 4'b1000;
    stepOnce(1'b0, 1'b1);
    advN(1);
    chk("R9 no trig before wrap", wrapTrig, 0);
    advN(1);
    chk("R7 no carry when disabled", colAddr, 0);
    chk("R9 trig on wrap", wrapTrig, 1);
    stepOnce(1'b0, 1'b0);
    chk("R9 trig single cycle", wrapTrig, 0);

    // R10: idle holds
    advN(1);
    stepOnce(1'b0, 1'b0);
    stepOnce(1'b0, 1'b0);
    chk("R10 rank holds", rankAddr, 1);
    chk("R10 col holds", colAddr, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule